// File: doc/BRIEF.md
# Power Mode Transition Sequencer

This block moves a microcontroller from the operating mode it is in to a requested mode. A request names a target mode. The block then works through a fixed chain of steps, one after another, and each step starts only once the one before it has finished. The chain runs in this order:

1. Wake the flash arrays.
2. Restore or park the pad outputs.
3. Apply the peripheral clock gates.
4. Restore processor and memory clocks.
5. Wake the processor.
6. Switch the system clock.

Each mode has its own configuration word. The word gives the code-flash and data-flash power settings, a pad-disable bit and a system clock source. The block copies the target mode's word when it accepts the request. The flash arrays, the processor and the internal RC oscillator are outside the block. They answer through acknowledge and ready inputs.

Top module: `pwr_mode_seq`

## Requirements
- R1: Mode codes are 0 = reset, 1..4 = run0..run3, 5 = halt, 6 = stop. A request carrying any code from 7 to 15 is dropped: busy stays low and the current mode does not change.
- R2: busy goes high in the cycle after a request is accepted and stays high until the transition finishes. A request that arrives while busy is ignored and does not change the mode the transition ends in.
- R3: A configuration word holds these fields: bits [1:0] code-flash setting, bits [3:2] data-flash setting, bit 4 pad-disable, bits [6:5] clock source. Flash codes are 00 reserved, 01 power-down, 10 low-power, 11 normal. On acceptance, each flash power request output takes the target code. A flash wake output is raised when the setting in force is not 11 and the target is 11.
- R4: A flash status field takes the target code when that code is not 11. For a woken flash, the status becomes 11 and the wake output drops in the cycle after the flash reports ready.
- R5: A change between low-power and power-down is forwarded as an ordinary request, with no wake and no error indication.
- R6: After the flash step, the pad output enable and the pad power driver enable are both set to the inverse of the target pad-disable bit.
- R7: After the pad step, the peripheral clock gate vector becomes the target mode's peripheral mask ANDed with the per-peripheral control vector. The mask for mode m is bits [m*NPERIPH +: NPERIPH].
- R8: On a transition from halt or stop into run0..run3, the processor and memory clock enables go to 1. On a transition into halt or stop, they go to 0. Otherwise they are left unchanged.
- R9: On a halt or stop to run transition, a processor wake request is raised after the clocks are enabled and held until it is acknowledged. It is never high while a flash wake is pending. No other transition raises it.
- R10: The system clock select takes the target clock code. If the target is the internal RC oscillator (code 00) and it differs from the current code, the select does not change while the oscillator-stable input is low. Other codes take effect without waiting.
- R11: When the clock step completes, the current mode takes the target. At the same time a one-cycle done pulse is issued and busy falls.
- R12: After reset the state is as follows:
  - current mode is 0
  - flash requests and statuses are 11
  - pad enables are 1
  - peripheral gates are 0
  - processor and memory clocks are 1
  - processor wake is 0
  - clock select is 00
  - busy and done are 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transition request strobe |
| req_mode | input | 4 | Requested target mode code |
| mode_cfg | input | 49 | Seven 7-bit configuration words, mode m at bits [m*7 +: 7] |
| periph_mask | input | 7*NPERIPH | Per-mode peripheral clock masks |
| periph_ctl | input | NPERIPH | Per-peripheral clock permission |
| cflash_rdy | input | 1 | Code flash reports it is accessible |
| dflash_rdy | input | 1 | Data flash reports it is accessible |
| cpu_wake_ack | input | 1 | Processor acknowledges the wake request |
| irc_stable | input | 1 | Internal RC oscillator is stable |
| cflash_pwr_req | output | 2 | Code flash power setting requested |
| dflash_pwr_req | output | 2 | Data flash power setting requested |
| cflash_wake | output | 1 | Code flash wake request |
| dflash_wake | output | 1 | Data flash wake request |
| cflash_stat | output | 2 | Code flash status field |
| dflash_stat | output | 2 | Data flash status field |
| pad_oe | output | 1 | Pad output enable |
| pad_drv_en | output | 1 | Pad power sequence driver enable |
| periph_clk_en | output | NPERIPH | Peripheral clock gates |
| cpu_clk_en | output | 1 | Processor clock enable |
| mem_clk_en | output | 1 | System memory clock enable |
| cpu_wake_req | output | 1 | Processor wake request |
| sys_clk_sel | output | 2 | Selected system clock source |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle transition completion pulse |
| cur_mode | output | 4 | Current mode code |

## Verification
The bench first walks a directed chain that exercises the main paths:
- reset to run, where no flash needs waking
- run to halt, which parks the pads, stops the clocks and puts the flash in low-power and power-down
- halt to stop, which swaps low-power and power-down and switches to the RC oscillator behind a late stable flag
- stop to run, with delayed flash ready and processor acknowledge

This chain separates the cases that need a wake from those that only forward a setting. It also separates the core-clock handling of entering a low-power mode from that of leaving one. Random transitions then combine random configuration words, masks, response delays and stable-flag timing. Some of them also poke a second request mid-flight, which shows whether in-flight requests are ignored. Illegal codes at idle and a same-mode request complete the set.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int NPERIPH = 8,
  localparam int NMODES = 7,
  localparam int CFG_W = 7,
  localparam int MODE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [MODE_W-1:0]           req_mode,
  input  logic [NMODES*CFG_W-1:0]     mode_cfg,
  input  logic [NMODES*NPERIPH-1:0]   periph_mask,
  input  logic [NPERIPH-1:0]          periph_ctl,
  input  logic                        cflash_rdy,
  input  logic                        dflash_rdy,
  input  logic                        cpu_wake_ack,
  input  logic                        irc_stable,
  output logic [1:0]                  cflash_pwr_req,
  output logic [1:0]                  dflash_pwr_req,
  output logic                        cflash_wake,
  output logic                        dflash_wake,
  output logic [1:0]                  cflash_stat,
  output logic [1:0]                  dflash_stat,
  output logic                        pad_oe,
  output logic                        pad_drv_en,
  output logic [NPERIPH-1:0]          periph_clk_en,
  output logic                        cpu_clk_en,
  output logic                        mem_clk_en,
  output logic                        cpu_wake_req,
  output logic [1:0]                  sys_clk_sel,
  output logic                        busy,
  output logic                        done,
  output logic [MODE_W-1:0]           cur_mode
);
  localparam logic [1:0] FL_NORMAL = 2'b11;
  localparam logic [1:0] CLK_RC = 2'b00;
  localparam logic [MODE_W-1:0] M_HALT = MODE_W'(5);
  localparam logic [MODE_W-1:0] M_STOP = MODE_W'(6);

  typedef enum logic [2:0] {
    S_IDLE, S_FLASH, S_PADS, S_PERI, S_CORE, S_WAKE, S_CLK
  } seq_state_t;

  seq_state_t          st;
  logic [MODE_W-1:0]   tgt;
  logic [CFG_W-1:0]    tcfg;
  logic [CFG_W-1:0]    rcfg;
  logic [NPERIPH-1:0]  tmask;
  logic                accept, cur_lp, tgt_lp, tgt_run, clk_ok;

  always_comb begin
    rcfg = '0;
    tmask = '0;
    for (int i = 0; i < NMODES; i++) begin
      if (req_mode == MODE_W'(i)) rcfg = mode_cfg[i*CFG_W +: CFG_W];
      if (tgt == MODE_W'(i)) tmask = periph_mask[i*NPERIPH +: NPERIPH];
    end
  end

  assign accept  = (st == S_IDLE) && req_valid && (req_mode < MODE_W'(NMODES));
  assign busy    = (st != S_IDLE);
  assign cur_lp  = (cur_mode == M_HALT) || (cur_mode == M_STOP);
  assign tgt_lp  = (tgt == M_HALT) || (tgt == M_STOP);
  assign tgt_run = (tgt >= MODE_W'(1)) && (tgt <= MODE_W'(4));
  assign clk_ok  = (tcfg[6:5] == sys_clk_sel) || (tcfg[6:5] != CLK_RC) || irc_stable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tgt <= '0;
      tcfg <= '0;
      cur_mode <= '0;
      cflash_pwr_req <= FL_NORMAL;
      dflash_pwr_req <= FL_NORMAL;
      cflash_stat <= FL_NORMAL;
      dflash_stat <= FL_NORMAL;
      cflash_wake <= 1'b0;
      dflash_wake <= 1'b0;
      pad_oe <= 1'b1;
      pad_drv_en <= 1'b1;
      periph_clk_en <= '0;
      cpu_clk_en <= 1'b1;
      mem_clk_en <= 1'b1;
      cpu_wake_req <= 1'b0;
      sys_clk_sel <= CLK_RC;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          tgt <= req_mode;
          tcfg <= rcfg;
          cflash_pwr_req <= rcfg[1:0];
          dflash_pwr_req <= rcfg[3:2];
          cflash_wake <= (cflash_pwr_req != FL_NORMAL) && (rcfg[1:0] == FL_NORMAL);
          dflash_wake <= (dflash_pwr_req != FL_NORMAL) && (rcfg[3:2] == FL_NORMAL);
          if (rcfg[1:0] != FL_NORMAL) cflash_stat <= rcfg[1:0];
          if (rcfg[3:2] != FL_NORMAL) dflash_stat <= rcfg[3:2];
          st <= S_FLASH;
        end
        S_FLASH: begin
          if (cflash_wake && cflash_rdy) begin
            cflash_wake <= 1'b0;
            cflash_stat <= FL_NORMAL;
          end
          if (dflash_wake && dflash_rdy) begin
            dflash_wake <= 1'b0;
            dflash_stat <= FL_NORMAL;
          end
          if ((!cflash_wake || cflash_rdy) && (!dflash_wake || dflash_rdy)) st <= S_PADS;
        end
        S_PADS: begin
          pad_oe <= !tcfg[4];
          pad_drv_en <= !tcfg[4];
          st <= S_PERI;
        end
        S_PERI: begin
          periph_clk_en <= tmask & periph_ctl;
          st <= S_CORE;
        end
        S_CORE: begin
          if (cur_lp && tgt_run) begin
            cpu_clk_en <= 1'b1;
            mem_clk_en <= 1'b1;
            st <= S_WAKE;
          end else begin
            if (tgt_lp) begin
              cpu_clk_en <= 1'b0;
              mem_clk_en <= 1'b0;
            end
            st <= S_CLK;
          end
        end
        S_WAKE: begin
          if (!cpu_wake_req) cpu_wake_req <= 1'b1;
          else if (cpu_wake_ack) begin
            cpu_wake_req <= 1'b0;
            st <= S_CLK;
          end
        end
        S_CLK: if (clk_ok) begin
          sys_clk_sel <= tcfg[6:5];
          cur_mode <= tgt;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_mode,
  input logic       cflash_rdy,
  input logic       dflash_rdy,
  input logic       irc_stable,
  input logic       cflash_wake,
  input logic       dflash_wake,
  input logic [1:0] cflash_stat,
  input logic [1:0] dflash_stat,
  input logic       cpu_wake_req,
  input logic       cpu_clk_en,
  input logic [1:0] sys_clk_sel,
  input logic       busy,
  input logic       done,
  input logic [3:0] cur_mode
);
  assert_reject_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_mode > 4'd6) |=> !busy);

  assert_mode_only_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> done);

  assert_cflash_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cflash_wake && cflash_rdy) |=> (cflash_stat == 2'b11 && !cflash_wake));

  assert_dflash_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dflash_wake && dflash_rdy) |=> (dflash_stat == 2'b11 && !dflash_wake));

  assert_wake_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wake_req |-> (cpu_clk_en && !cflash_wake && !dflash_wake));

  assert_rc_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_sel != 2'b00 && !irc_stable) |=> sys_clk_sel != 2'b00);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .cflash_rdy(cflash_rdy), .dflash_rdy(dflash_rdy), .irc_stable(irc_stable),
  .cflash_wake(cflash_wake), .dflash_wake(dflash_wake),
  .cflash_stat(cflash_stat), .dflash_stat(dflash_stat),
  .cpu_wake_req(cpu_wake_req), .cpu_clk_en(cpu_clk_en),
  .sys_clk_sel(sys_clk_sel), .busy(busy), .done(done), .cur_mode(cur_mode)
);

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
  localparam int NP = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_mode = '0;
  logic [48:0] mode_cfg = '0;
  logic [7*NP-1:0] periph_mask = '0;
  logic [NP-1:0] periph_ctl = '0;
  logic cflash_rdy = 1'b0, dflash_rdy = 1'b0, cpu_wake_ack = 1'b0, irc_stable = 1'b0;
  logic [1:0] cflash_pwr_req, dflash_pwr_req, cflash_stat, dflash_stat, sys_clk_sel;
  logic cflash_wake, dflash_wake, pad_oe, pad_drv_en, cpu_clk_en, mem_clk_en;
  logic cpu_wake_req, busy, done;
  logic [NP-1:0] periph_clk_en;
  logic [3:0] cur_mode;

  int checks = 0, errors = 0;
  logic [3:0] m_cur = 0;
  logic [1:0] m_cpwr = 2'b11, m_dpwr = 2'b11, m_sclk = 2'b00;
  logic m_pad = 1'b1, m_cclk = 1'b1;
  logic [NP-1:0] m_per = '0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.NPERIPH(NP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .mode_cfg(mode_cfg), .periph_mask(periph_mask), .periph_ctl(periph_ctl),
    .cflash_rdy(cflash_rdy), .dflash_rdy(dflash_rdy), .cpu_wake_ack(cpu_wake_ack),
    .irc_stable(irc_stable), .cflash_pwr_req(cflash_pwr_req), .dflash_pwr_req(dflash_pwr_req),
    .cflash_wake(cflash_wake), .dflash_wake(dflash_wake), .cflash_stat(cflash_stat),
    .dflash_stat(dflash_stat), .pad_oe(pad_oe), .pad_drv_en(pad_drv_en),
    .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en),
    .cpu_wake_req(cpu_wake_req), .sys_clk_sel(sys_clk_sel), .busy(busy), .done(done),
    .cur_mode(cur_mode)
  );

  function automatic bit is_lp(input logic [3:0] m);  return m == 5 || m == 6; endfunction
  function automatic bit is_run(input logic [3:0] m); return m >= 1 && m <= 4; endfunction
  function automatic bit needs_wake(input logic [1:0] prev, input logic [1:0] t);
    return prev != 2'b11 && t == 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_trans(input logic [3:0] t, input logic [6:0] w, input int cd, input int dd,
                           input int ad, input int sd, input bit poke);
    logic [NP-1:0] mk;
    bit wait_rc, exp_cw, exp_dw, exp_wk, saw_wk, prev_stab, viol;
    logic [1:0] old_clk;
    int cnt, wk;
    mk = NP'($urandom);
    @(negedge clk);
    mode_cfg[t*7 +: 7] = w;
    periph_mask[t*NP +: NP] = mk;
    periph_ctl = NP'($urandom);
    wait_rc = (w[6:5] == 2'b00) && (m_sclk != 2'b00);
    exp_cw = needs_wake(m_cpwr, w[1:0]);
    exp_dw = needs_wake(m_dpwr, w[3:2]);
    exp_wk = is_lp(m_cur) && is_run(t);
    old_clk = m_sclk;
    req_valid = 1'b1; req_mode = t;
    irc_stable = wait_rc ? 1'b0 : 1'($urandom);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", 32'(busy), 1);
    chk("R3 code flash request", 32'(cflash_pwr_req), 32'(w[1:0]));
    chk("R3 data flash request", 32'(dflash_pwr_req), 32'(w[3:2]));
    chk("R3 R5 code flash wake", 32'(cflash_wake), 32'(exp_cw));
    chk("R3 R5 data flash wake", 32'(dflash_wake), 32'(exp_dw));
    cnt = 0; wk = 0; saw_wk = 0; viol = 0; prev_stab = irc_stable;
    while (!done && cnt < 400) begin
      if (wait_rc && !prev_stab && sys_clk_sel != old_clk) viol = 1;
      if (cpu_wake_req) begin saw_wk = 1; wk++; end
      cflash_rdy = cflash_wake && cnt >= cd;
      dflash_rdy = dflash_wake && cnt >= dd;
      cpu_wake_ack = cpu_wake_req && wk > ad;
      if (wait_rc) irc_stable = (cnt >= sd);
      prev_stab = irc_stable;
      req_valid = poke && cnt == 1;
      req_mode = 4'((t + 1) % 7);
      @(negedge clk);
      cnt++;
    end
    if (wait_rc && !prev_stab && sys_clk_sel != old_clk) viol = 1;
    req_valid = 1'b0; cflash_rdy = 1'b0; dflash_rdy = 1'b0; cpu_wake_ack = 1'b0;
    m_cur = t; m_cpwr = w[1:0]; m_dpwr = w[3:2]; m_sclk = w[6:5];
    m_pad = !w[4]; m_per = mk & periph_ctl;
    if (exp_wk) m_cclk = 1'b1; else if (is_lp(t)) m_cclk = 1'b0;
    chk("R11 done pulse", 32'(done), 1);
    chk("R11 busy low at done", 32'(busy), 0);
    chk("R2 R11 mode updated", 32'(cur_mode), 32'(m_cur));
    chk("R4 code flash status", 32'(cflash_stat), 32'(m_cpwr));
    chk("R4 data flash status", 32'(dflash_stat), 32'(m_dpwr));
    chk("R6 pad enable", 32'(pad_oe), 32'(m_pad));
    chk("R6 pad driver", 32'(pad_drv_en), 32'(m_pad));
    chk("R7 peripheral gates", 32'(periph_clk_en), 32'(m_per));
    chk("R8 cpu clock", 32'(cpu_clk_en), 32'(m_cclk));
    chk("R8 memory clock", 32'(mem_clk_en), 32'(m_cclk));
    chk("R9 processor wake seen", 32'(saw_wk), 32'(exp_wk));
    chk("R10 clock select", 32'(sys_clk_sel), 32'(m_sclk));
    chk("R10 no switch before stable", 32'(viol), 0);
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 0);
  endtask

  task automatic reject(input logic [3:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_mode = c;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 illegal code not accepted", 32'(busy), 0);
    @(negedge clk);
    chk("R1 mode kept", 32'(cur_mode), 32'(m_cur));
    chk("R1 no done", 32'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R12 reset mode", 32'(cur_mode), 0);
    chk("R12 reset flash status", 32'({cflash_stat, dflash_stat, cflash_pwr_req, dflash_pwr_req}), 32'hff);
    chk("R12 reset pads", 32'({pad_oe, pad_drv_en}), 3);
    chk("R12 reset clocks", 32'({cpu_clk_en, mem_clk_en, cpu_wake_req, sys_clk_sel}), 32'b11000);
    chk("R12 reset gates busy done", 32'({periph_clk_en, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_trans(4'd1, 7'b10_0_11_11, 0, 0, 0, 0, 1'b0);
    run_trans(4'd5, 7'b10_1_01_10, 0, 0, 0, 0, 1'b1);
    run_trans(4'd6, 7'b00_1_10_01, 0, 0, 0, 4, 1'b0);
    run_trans(4'd2, 7'b01_0_11_11, 3, 1, 2, 0, 1'b1);
    reject(4'd7);
    reject(4'd9);
    reject(4'd15);
    run_trans(4'd2, 7'b00_0_11_11, 0, 0, 0, 5, 1'b0);
    for (int i = 0; i < 40; i++)
      run_trans(4'($urandom % 7), 7'($urandom), int'($urandom % 5), int'($urandom % 5),
                int'($urandom % 4), int'($urandom % 7), 1'($urandom));
    summary();
  end
endmodule